// File: doc/BRIEF.md
# Serial configuration EEPROM reader with capacity detection

This block reads configuration words out of a three-wire serial EEPROM after reset: chip select, serial clock, a command line into the memory and a data line out of it. When reset is released it checks the level on the data-in pin. A high level means a memory is fitted. A low level means no memory is fitted, and the block finishes at once without touching the pins.

When a memory is present, the first command is a read of word 0. While that command is being clocked, the block works out how many address bits the part uses. It does this by looking at the data-in line on the tenth rising clock edge. Word 0 tells the block two things:
- whether configuration data is stored: its high byte must match a tag;
- how many further words follow: its low byte holds the count.

Every word is handed to the consumer on a valid/ready port together with its word address. The serial clock is divided down from the system clock to 1 MHz.

Top module: `mw_eeprom_reader`

## Requirements
- R1: While reset is low, chip select, word_valid and done are all low. If data-in is low on the first clock edge after reset is released, done goes high on that edge, chip select never rises and cfg_found stays 0.
- R2: Each read command works as follows:
  - chip select rises with the serial clock low and the start bit already on data-out;
  - the command bits sampled on the rising edges are 1, 1, 0, followed by the word address MSB first, using the detected address width;
  - whenever chip select is low, the serial clock is low.
- R3: The serial clock period is 2*HALF system cycles, with HALF = SYS_HZ/(2*SK_HZ). The clock is high for HALF cycles and low for HALF cycles, and the first rise comes HALF cycles after chip select rises.
- R4: Capacity is detected on the tenth rising edge of the first command:
  - data-in low there sets large_dev to 0, giving a 6-bit address and 26 rising edges per command;
  - data-in high sets large_dev to 1, giving an 8-bit address and 28 rising edges per command.
- R5: Data-in is sampled on rising edges. After the address, one dummy bit is skipped and then 16 data bits are taken MSB first. The finished word appears on word_data, with its address on word_addr, while word_valid is high. Both stay stable until word_ready is high.
- R6: cfg_found is 1 only if bits [15:8] of word 0 equal CFG_TAG. Otherwise reading stops after word 0.
- R7: When cfg_found is 1, bits [7:0] of word 0 give a count N. Words 1 to N are then read in ascending order and done goes high. If N is 0, only word 0 is read.
- R8: Between two commands, chip select stays low for at least 2*HALF system cycles.
- R9: Once done is high, it stays high, and chip select and word_valid stay low until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ee_di | input | 1 | Serial data from the EEPROM; it is also the presence sense at reset release |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | Serial clock to the EEPROM |
| ee_do | output | 1 | Serial command and address bits to the EEPROM |
| word_valid | output | 1 | A word is on word_data |
| word_ready | input | 1 | The consumer accepts the word |
| word_data | output | 16 | The word read from the EEPROM |
| word_addr | output | 8 | The EEPROM word address of word_data |
| done | output | 1 | Reading has finished |
| cfg_found | output | 1 | Word 0 carried the configuration tag |
| large_dev | output | 1 | An 8-bit address device was detected |

## Verification
The presence decision is registered on the first clock edge after reset is released. The bench therefore samples done or chip select two falling edges after it releases reset. The serial-clock checks count system cycles between level changes seen on falling edges: HALF between a rise and the next fall, 2*HALF between rises, and HALF from chip select to the first rise. A word is checked on the falling edge where word_valid and word_ready are both high. Its hold is checked on every falling edge that follows a stalled one. The count, tag, capacity and idle checks are made 40 cycles after done, so any late activity on chip select or word_valid would be caught.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        ST_SENSE,
        ST_SHIFT,
        ST_WAIT,
        ST_DONE
    } rd_state_e;

    // Level on the command line for rising edge n (counted from 1) of a read.
    function automatic logic cmd_bit(input logic [4:0] n,
                                     input logic [7:0] addr,
                                     input logic       wide);
        logic [4:0] last_a;
        logic [2:0] idx;
        last_a = wide ? 5'd11 : 5'd9;
        idx    = 3'(last_a - n);
        if (n == 5'd1 || n == 5'd2) return 1'b1;
        if (n == 5'd3)              return 1'b0;
        if (n >= 5'd4 && n <= last_a) return addr[idx];
        return 1'b0;
    endfunction

endpackage

// File: rtl/mw_sk_gen.sv
module mw_sk_gen #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic sk,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF < 2) ? 1 : $clog2(HALF);

    typedef struct packed {
        logic [CW-1:0] div;
        logic          sk;
    } skg_t;

    skg_t q, d;

    always_comb begin
        d    = q;
        rise = 1'b0;
        fall = 1'b0;
        if (!en) begin
            d = '0;
        end else if (q.div == CW'(HALF - 1)) begin
            d.div = '0;
            d.sk  = !q.sk;
            rise  = !q.sk;
            fall  = q.sk;
        end else begin
            d.div = q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sk = q.sk;

    assert_sk_idle_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sk);

endmodule

// File: rtl/mw_gap_timer.sv
module mw_gap_timer #(
    parameter int LIM = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int CW = $clog2(LIM + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (start)                   cnt_d = '0;
        else if (cnt_q != CW'(LIM))  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= CW'(LIM);
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == CW'(LIM));

endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
    import mw_eeprom_pkg::*;
#(
    parameter int         SYS_HZ  = 8_000_000,
    parameter int         SK_HZ   = 1_000_000,
    parameter logic [7:0] CFG_TAG = 8'hC5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ee_di,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_do,
    output logic              word_valid,
    input  logic              word_ready,
    output logic [WORD_W-1:0] word_data,
    output logic [7:0]        word_addr,
    output logic              done,
    output logic              cfg_found,
    output logic              large_dev
);
    localparam int HALF    = SYS_HZ / (2 * SK_HZ);
    localparam int GAP_LIM = 2 * HALF;

    typedef struct packed {
        rd_state_e         st;
        logic [4:0]        edge_n;
        logic              wide;
        logic              first;
        logic [WORD_W-1:0] sh;
        logic              do_b;
        logic              valid;
        logic [WORD_W-1:0] data;
        logic [7:0]        addr;
        logic [7:0]        cnt;
        logic              found;
        logic              stop;
    } rd_t;

    rd_t  q, d;
    logic sk_en, rise, fall, sk;
    logic gap_start, gap_exp;
    logic [4:0] n_next;

    mw_sk_gen #(.HALF(HALF)) sk_gen_i (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (sk_en),
        .sk   (sk),
        .rise (rise),
        .fall (fall)
    );

    mw_gap_timer #(.LIM(GAP_LIM)) gap_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (gap_start),
        .expired(gap_exp)
    );

    assign sk_en  = (q.st == ST_SHIFT);
    assign n_next = q.edge_n + 5'd1;

    always_comb begin
        d         = q;
        gap_start = 1'b0;
        case (q.st)
            ST_SENSE: begin
                if (ee_di) begin
                    d.st     = ST_SHIFT;
                    d.do_b   = 1'b1;
                    d.edge_n = '0;
                end else begin
                    d.st = ST_DONE;
                end
            end
            ST_SHIFT: begin
                if (rise) begin
                    d.edge_n = n_next;
                    if (q.first && n_next == 5'd10) d.wide = ee_di;
                    if (n_next >= (q.wide ? 5'd13 : 5'd11))
                        d.sh = {q.sh[WORD_W-2:0], ee_di};
                end
                if (fall) begin
                    if (q.edge_n == (q.wide ? 5'd28 : 5'd26)) begin
                        d.st      = ST_WAIT;
                        d.valid   = 1'b1;
                        d.data    = q.sh;
                        d.first   = 1'b0;
                        d.do_b    = 1'b0;
                        gap_start = 1'b1;
                    end else begin
                        d.do_b = cmd_bit(n_next, q.addr, q.wide);
                    end
                end
            end
            ST_WAIT: begin
                if (q.valid && word_ready) begin
                    d.valid = 1'b0;
                    if (q.addr == 8'd0) begin
                        d.found = (q.data[15:8] == CFG_TAG);
                        d.cnt   = q.data[7:0];
                        d.stop  = (q.data[15:8] != CFG_TAG) || (q.data[7:0] == 8'd0);
                    end else begin
                        d.stop  = (q.addr == q.cnt);
                    end
                end else if (!q.valid && gap_exp) begin
                    if (q.stop) begin
                        d.st = ST_DONE;
                    end else begin
                        d.st     = ST_SHIFT;
                        d.addr   = q.addr + 8'd1;
                        d.edge_n = '0;
                        d.do_b   = 1'b1;
                        d.sh     = '0;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_SENSE;
            q.first <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ee_cs      = (q.st == ST_SHIFT);
    assign ee_sk      = sk;
    assign ee_do      = q.do_b;
    assign word_valid = q.valid;
    assign word_data  = q.data;
    assign word_addr  = q.addr;
    assign done       = (q.st == ST_DONE);
    assign cfg_found  = q.found;
    assign large_dev  = q.wide;

    assert_sk_low_when_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sk);

    assert_start_bit_on_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs) |-> (ee_do && !ee_sk));

    assert_word_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_ready) |=> (word_valid && $stable(word_data) && $stable(word_addr)));

    assert_select_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ee_cs) && $past(q.st) == ST_WAIT) |-> $past(gap_exp));

    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && !ee_cs && !word_valid));

endmodule

// File: tb/mw_eeprom_reader_tb.sv
`timescale 1ns/1ps
module mw_eeprom_reader_tb_top;

    localparam int         CLK_PERIOD = 124;
    localparam int         SYS_HZ     = 8_000_000;
    localparam int         SK_HZ      = 1_000_000;
    localparam int         HALF       = SYS_HZ / (2 * SK_HZ);
    localparam logic [7:0] TAG        = 8'hC5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic word_ready = 1'b0;
    logic ee_cs, ee_sk, ee_do, word_valid, done, cfg_found, large_dev;
    logic [15:0] word_data;
    logic [7:0]  word_addr;

    logic pull = 1'b1;
    logic drv_en = 1'b0;
    logic drv_val = 1'b0;
    wire  ee_di = drv_en ? drv_val : pull;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mw_eeprom_reader #(.SYS_HZ(SYS_HZ), .SK_HZ(SK_HZ), .CFG_TAG(TAG)) dut_i (
        .clk(clk), .rst_n(rst_n), .ee_di(ee_di), .ee_cs(ee_cs), .ee_sk(ee_sk),
        .ee_do(ee_do), .word_valid(word_valid), .word_ready(word_ready),
        .word_data(word_data), .word_addr(word_addr), .done(done),
        .cfg_found(cfg_found), .large_dev(large_dev)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int cmd_edges(input bit wide);
        return wide ? 28 : 26;
    endfunction

    function automatic int mem_index(input int a, input bit wide);
        return wide ? (a % 256) : (a % 64);
    endfunction

    // EEPROM model
    logic [15:0] mem [256];
    bit          wide_dev = 1'b0;
    int          bitn = 0;
    logic [2:0]  cmd_rx = '0;
    logic [7:0]  addr_rx = '0;
    int          exp_cmd_addr = 0;
    int          cmd_bad = 0;

    always @(posedge ee_cs) begin
        bitn    = 0;
        cmd_rx  = '0;
        addr_rx = '0;
    end

    always @(posedge ee_sk) begin
        if (ee_cs) begin
            int aw;
            aw = wide_dev ? 8 : 6;
            bitn = bitn + 1;
            if (bitn <= 3) cmd_rx = {cmd_rx[1:0], ee_do};
            else if (bitn <= 3 + aw) addr_rx = {addr_rx[6:0], ee_do};
            if (bitn == 3 + aw) begin
                drv_en  <= 1'b1;
                drv_val <= 1'b0;
            end else if (bitn >= 4 + aw && bitn <= 19 + aw) begin
                drv_val <= mem[mem_index(int'(addr_rx), wide_dev)][19 + aw - bitn];
            end
        end
    end

    always @(negedge ee_cs) begin
        drv_en <= 1'b0;
        if (rst_n) begin
            if (cmd_rx != 3'b110) cmd_bad++;
            if (int'(addr_rx) != mem_index(exp_cmd_addr, wide_dev)) cmd_bad++;
            exp_cmd_addr++;
        end
    end

    // Monitors on the falling clock edge
    int   cyc = 0;
    logic sk_prev = 1'b0, cs_prev = 1'b0;
    int   last_rise = 0, cs_rise_cyc = 0, cs_fall_cyc = -1000;
    int   rises = 0;
    int   sk_bad = 0, per_bad = 0, edge_bad = 0, gap_bad = 0, hold_bad = 0, late_bad = 0;
    int   n_words = 0, exp_word = 0;
    bit   cs_seen = 1'b0, hold = 1'b0;
    logic [15:0] held_data;
    logic [7:0]  held_addr;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!ee_cs && ee_sk) sk_bad++;
            if (ee_cs && !cs_prev) begin
                cs_seen = 1'b1;
                rises = 0;
                cs_rise_cyc = cyc;
                if (cyc - cs_fall_cyc < 2 * HALF) gap_bad++;
            end
            if (!ee_cs && cs_prev) begin
                cs_fall_cyc = cyc;
                if (rises != cmd_edges(wide_dev)) edge_bad++;
            end
            if (ee_sk && !sk_prev) begin
                rises++;
                if (rises == 1 && cyc - cs_rise_cyc != HALF) per_bad++;
                if (rises > 1 && cyc - last_rise != 2 * HALF) per_bad++;
                last_rise = cyc;
            end
            if (!ee_sk && sk_prev && cyc - last_rise != HALF) per_bad++;
            if (done && (ee_cs || word_valid)) late_bad++;
            if (hold && !(word_valid && word_data == held_data && word_addr == held_addr))
                hold_bad++;
            hold = 1'b0;
            if (word_valid && word_ready) begin
                n_words++;
                chk(int'(word_addr) == exp_word, "R7", "word address order",
                    int'(word_addr), exp_word);
                chk(word_data == mem[mem_index(exp_word, wide_dev)], "R5", "word data",
                    int'(word_data), int'(mem[mem_index(exp_word, wide_dev)]));
                exp_word++;
            end else if (word_valid) begin
                hold = 1'b1;
                held_data = word_data;
                held_addr = word_addr;
            end
        end
        sk_prev = ee_sk;
        cs_prev = ee_cs;
    end

    initial begin
        forever begin
            @(posedge clk);
            #1 word_ready = (($urandom % 4) != 0);
        end
    end

    task automatic run_case(input bit present, input bit wide, input bit good, input int cnt);
        int wd;
        int exp_words;
        rst_n    = 1'b0;
        pull     = present;
        wide_dev = wide;
        for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
        mem[0] = {good ? TAG : ~TAG, 8'(cnt)};
        repeat (4) @(negedge clk);
        chk(!ee_cs && !word_valid && !done, "R1", "reset state (cs,valid,done)",
            int'({ee_cs, word_valid, done}), 0);
        exp_cmd_addr = 0; exp_word = 0; n_words = 0; cmd_bad = 0;
        sk_bad = 0; per_bad = 0; edge_bad = 0; gap_bad = 0; hold_bad = 0; late_bad = 0;
        cs_seen = 1'b0; hold = 1'b0; cs_fall_cyc = -1000;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        if (!present) chk(done && !ee_cs, "R1", "absent: done without select",
                          int'({done, ee_cs}), 2);
        else          chk(ee_cs && !done, "R1", "present: read started",
                          int'({ee_cs, done}), 2);
        wd = 0;
        while (!done && wd < 60000) begin
            @(negedge clk);
            wd++;
        end
        chk(done, "R9", "watchdog: done reached", int'(done), 1);
        repeat (40) @(negedge clk);
        exp_words = !present ? 0 : ((good && cnt > 0) ? cnt + 1 : 1);
        chk(n_words == exp_words, "R7", "words delivered", n_words, exp_words);
        chk(cfg_found == (present && good), "R6", "cfg_found", int'(cfg_found),
            int'(present && good));
        if (present) chk(large_dev == wide, "R4", "large_dev", int'(large_dev), int'(wide));
        else         chk(!cs_seen, "R1", "absent: select never rose", int'(cs_seen), 0);
        chk(cmd_bad == 0, "R2", "command bits/address", cmd_bad, 0);
        chk(sk_bad == 0, "R2", "clock while deselected", sk_bad, 0);
        chk(per_bad == 0, "R3", "serial clock timing", per_bad, 0);
        chk(edge_bad == 0, "R4", "edges per command", edge_bad, 0);
        chk(gap_bad == 0, "R8", "deselect gap", gap_bad, 0);
        chk(hold_bad == 0, "R5", "valid hold while stalled", hold_bad, 0);
        chk(late_bad == 0, "R9", "activity after done", late_bad, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL R9 watchdog expired: actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        run_case(1'b0, 1'b0, 1'b1, 3);
        run_case(1'b1, 1'b0, 1'b1, 5);
        run_case(1'b1, 1'b1, 1'b1, 9);
        run_case(1'b1, 1'b0, 1'b0, 4);
        run_case(1'b1, 1'b1, 1'b1, 0);
        for (int k = 0; k < 3; k++)
            run_case(1'b1, 1'($urandom % 2), 1'(($urandom % 4) != 0), 1 + int'($urandom % 12));
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule